// File: doc/BRIEF.md
# MDIO Management Master with Address Scan

This block is the management-port master for the clause-22 serial interface to one or more external Ethernet PHYs. It makes the MDC clock from the system clock and shifts frames out on MDIO. It has an output-enable for the pad and samples the PHY's reply on MDIO. A small control register holds the command bits. The PHY address, register address and write data come in on plain input pins.

A write or a read is started by setting its command bit. The command bit clears itself again. In scan mode the block runs read frames back to back with no further commands. It can step the PHY address upward from a base value to 1Fh and then wrap back to the base. Each completed frame raises a sticky done flag. For reads, the read data and the PHY address of that read are updated at the same moment. The 32-bit preamble can be left out.

All pins are plain control and status signals. The result registers are overwritten by each new read and take no back-pressure. A reader that needs every scan result must read each one before the next frame completes.

Top module: `mdio_mgmt_master`

## Requirements
- R1: The control register is 5 bits and resets to 0. Its fields are: bit 4 write-go, bit 3 read-go, bit 2 scan-step, bit 1 scan-enable, bit 0 preamble-off. A write with `ctl_we` loads all five bits, and `ctl_rdata` reads them back. The two go bits clear themselves one clock after they are written.
- R2: A 0-to-1 change of write-go starts a write frame. The frame is 32 ones, then 01, then 01, then `base_phy`, then `reg_addr`, then turnaround 10, then `wr_data`. Every field is sent most significant bit first.
- R3: A 0-to-1 change of read-go starts a read frame: 01, 10, `base_phy`, `reg_addr`. `mdio_oe` is low for the last 18 bits, which are the turnaround and 16 data bits. The data bits are sampled on the MDC rising edge into `rd_data`, and `rd_phy` takes the frame's PHY address.
- R4: A go-bit rising edge that arrives while `busy` is high starts no frame, either then or later.
- R5: When preamble-off is set, the 32 leading ones are left out of the frame.
- R6: While scan-enable is set and no command is starting, the block runs read frames back to back.
- R7: When scan-step is also set, each scan frame uses the next PHY address. The sequence starts at `base_phy`, counts up to 1Fh and then wraps back to `base_phy`.
- R8: When scan-step is clear, every scan frame uses `base_phy`.
- R9: Clearing scan-enable lets the frame in progress run to its last bit, and no frame follows it.
- R10: `done_flag` is set one clock after each frame ends, in the same cycle that a read updates `rd_data` and `rd_phy`. It stays set until `done_clr` is asserted.
- R11: The MDC period is 2*max(floor(`div_cfg`/2),2) clocks. MDC and `mdio_oe` are low when idle. MDIO changes only while MDC is low.
- R12: `busy` is high from the start of a frame until its last bit completes. That is 4*(frame bits) clocks at `div_cfg`=4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| ctl_we | input | 1 | Load control register |
| ctl_wdata | input | 5 | Control register write value |
| ctl_rdata | output | 5 | Control register readback |
| base_phy | input | 5 | PHY address / scan base |
| reg_addr | input | 5 | PHY register address |
| wr_data | input | 16 | Data for write frames |
| div_cfg | input | DIV_W | MDC divide setting |
| done_clr | input | 1 | Clears done_flag |
| mdio_i | input | 1 | MDIO pad input |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO pad output value |
| mdio_oe | output | 1 | MDIO pad output enable |
| busy | output | 1 | Frame in progress |
| done_flag | output | 1 | Sticky frame-complete flag |
| rd_data | output | 16 | Last read result |
| rd_phy | output | 5 | PHY address of last read |

## Verification
A control write takes effect on the next edge. The go-bit edge is then registered, so `busy` rises on the second edge after the write. The frame then lasts exactly 4 clocks per bit at the default divide. `rd_data`, `rd_phy` and `done_flag` follow one edge after `busy` falls. The bench therefore waits for `busy` to fall and samples these results on the second falling clock edge after that. The bench's PHY model sees MDC edges one clock late. It captures driven bits at each MDC rise and drives reply bits after each MDC fall, which leaves at least one clock before the master samples.

// File: rtl/mdio_pkg.sv
`timescale 1ns/1ps
package mdio_pkg;
  localparam int PHY_W     = 5;
  localparam int REG_W     = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int FRAME_LEN = PRE_LEN + 4 + PHY_W + REG_W + 2 + DATA_W;
  localparam int CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int RELEASE_LEN = DATA_W + 2;

  localparam int CTL_W     = 5;
  localparam int CTL_NOPRE = 0;
  localparam int CTL_SCAN  = 1;
  localparam int CTL_STEP  = 2;
  localparam int CTL_RD    = 3;
  localparam int CTL_WR    = 4;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] TURN_WR    = 2'b10;
  localparam logic [1:0] TURN_RD    = 2'b11;
  localparam logic [PHY_W-1:0] PHY_TOP = '1;

  typedef enum logic [1:0] {
    OP_WR = 2'b01,
    OP_RD = 2'b10
  } mdio_op_e;

  typedef struct packed {
    mdio_op_e          op;
    logic [PHY_W-1:0]  phy;
    logic [REG_W-1:0]  regad;
    logic [DATA_W-1:0] wdata;
    logic              no_pre;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clkgen.sv
`timescale 1ns/1ps
module mdio_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_cfg,
  output logic             mdc,
  output logic             rise_stb,
  output logic             end_stb
);
  localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);
  localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

  logic [DIV_W-1:0] half;
  logic [DIV_W-1:0] cnt;
  logic             last;

  // half period in clocks, floored at two so the divide is never below four
  always_comb begin
    half = div_cfg >> 1;
    if (half < MIN_HALF) half = MIN_HALF;
  end

  assign last     = (cnt >= half - ONE);
  assign rise_stb = run && !mdc && last;
  assign end_stb  = run && mdc && last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (!run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (last) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + ONE;
    end
  end
endmodule

// File: rtl/mdio_frame.sv
`timescale 1ns/1ps
module mdio_frame
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  mdio_cmd_t         cmd,
  input  logic              rise_stb,
  input  logic              end_stb,
  input  logic              mdio_i,
  output logic              busy,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              done,
  output logic              is_rd,
  output logic [PHY_W-1:0]  phy_q,
  output logic [DATA_W-1:0] cap
);
  localparam logic [CNT_W-1:0] LEN_FULL  = CNT_W'(FRAME_LEN);
  localparam logic [CNT_W-1:0] LEN_SHORT = CNT_W'(FRAME_LEN - PRE_LEN);
  localparam logic [CNT_W-1:0] LEN_DATA  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] LEN_REL   = CNT_W'(RELEASE_LEN);
  localparam logic [CNT_W-1:0] ONE       = CNT_W'(1);

  logic [FRAME_LEN-1:0] word;
  logic [FRAME_LEN-1:0] sh;
  logic [CNT_W-1:0]     left;
  logic                 rd_cmd;

  assign rd_cmd = (cmd.op == OP_RD);

  always_comb begin
    word = {{PRE_LEN{1'b1}}, START_CODE, cmd.op, cmd.phy, cmd.regad,
            (rd_cmd ? TURN_RD : TURN_WR),
            (rd_cmd ? {DATA_W{1'b1}} : cmd.wdata)};
  end

  assign mdio_o  = busy ? sh[FRAME_LEN-1] : 1'b1;
  assign mdio_oe = busy && !(is_rd && (left <= LEN_REL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      sh    <= '0;
      left  <= '0;
      done  <= 1'b0;
      is_rd <= 1'b0;
      phy_q <= '0;
      cap   <= '0;
    end else begin
      done <= 1'b0;
      if (start && !busy) begin
        busy  <= 1'b1;
        sh    <= cmd.no_pre ? (word << PRE_LEN) : word;
        left  <= cmd.no_pre ? LEN_SHORT : LEN_FULL;
        is_rd <= rd_cmd;
        phy_q <= cmd.phy;
      end else if (busy) begin
        if (rise_stb && is_rd && (left <= LEN_DATA))
          cap <= {cap[DATA_W-2:0], mdio_i};
        if (end_stb) begin
          sh   <= sh << 1;
          left <= left - ONE;
          if (left == ONE) begin
            busy <= 1'b0;
            done <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_seq.sv
`timescale 1ns/1ps
module mdio_seq
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic              rd_go,
  input  logic              scan_en,
  input  logic              scan_step,
  input  logic              no_pre,
  input  logic [PHY_W-1:0]  base_phy,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic              start,
  output mdio_cmd_t         cmd
);
  logic [PHY_W-1:0] scan_phy;
  logic [PHY_W-1:0] scan_nxt;
  logic             take_scan;

  // priority: write command, then read command, then scan
  always_comb begin
    start     = 1'b0;
    take_scan = 1'b0;
    cmd.op     = OP_RD;
    cmd.phy    = base_phy;
    cmd.regad  = reg_addr;
    cmd.wdata  = wr_data;
    cmd.no_pre = no_pre;
    if (!busy) begin
      if (wr_go) begin
        start  = 1'b1;
        cmd.op = OP_WR;
      end else if (rd_go) begin
        start = 1'b1;
      end else if (scan_en) begin
        start     = 1'b1;
        take_scan = 1'b1;
        cmd.phy   = scan_phy;
      end
    end
  end

  assign scan_nxt = (scan_phy == PHY_TOP) ? base_phy : scan_phy + PHY_W'(1);

  // address advances when a scan frame is launched, so the next launch sees it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     scan_phy <= '0;
    else if (!scan_en)              scan_phy <= base_phy;
    else if (take_scan && scan_step) scan_phy <= scan_nxt;
  end
endmodule

// File: rtl/mdio_mgmt_master.sv
`timescale 1ns/1ps
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctl_we,
  input  logic [CTL_W-1:0]  ctl_wdata,
  output logic [CTL_W-1:0]  ctl_rdata,
  input  logic [PHY_W-1:0]  base_phy,
  input  logic [REG_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DIV_W-1:0]  div_cfg,
  input  logic              done_clr,
  input  logic              mdio_i,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  output logic              busy,
  output logic              done_flag,
  output logic [DATA_W-1:0] rd_data,
  output logic [PHY_W-1:0]  rd_phy
);
  logic [CTL_W-1:0]  ctl;
  logic              wr_prev, rd_prev;
  logic              wr_edge, rd_edge;
  logic              start;
  mdio_cmd_t         cmd;
  logic              rise_stb, end_stb;
  logic              fe_done, fe_is_rd;
  logic [PHY_W-1:0]  fe_phy;
  logic [DATA_W-1:0] fe_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= '0;
      wr_prev <= 1'b0;
      rd_prev <= 1'b0;
    end else begin
      if (ctl_we) begin
        ctl <= ctl_wdata;
      end else begin
        ctl[CTL_WR] <= 1'b0;
        ctl[CTL_RD] <= 1'b0;
      end
      wr_prev <= ctl[CTL_WR];
      rd_prev <= ctl[CTL_RD];
    end
  end

  assign ctl_rdata = ctl;
  assign wr_edge   = ctl[CTL_WR] && !wr_prev;
  assign rd_edge   = ctl[CTL_RD] && !rd_prev;

  mdio_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_go     (wr_edge),
    .rd_go     (rd_edge),
    .scan_en   (ctl[CTL_SCAN]),
    .scan_step (ctl[CTL_STEP]),
    .no_pre    (ctl[CTL_NOPRE]),
    .base_phy  (base_phy),
    .reg_addr  (reg_addr),
    .wr_data   (wr_data),
    .busy      (busy),
    .start     (start),
    .cmd       (cmd)
  );

  mdio_clkgen #(.DIV_W(DIV_W)) u_clk (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (busy),
    .div_cfg  (div_cfg),
    .mdc      (mdc),
    .rise_stb (rise_stb),
    .end_stb  (end_stb)
  );

  mdio_frame u_frame (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .cmd      (cmd),
    .rise_stb (rise_stb),
    .end_stb  (end_stb),
    .mdio_i   (mdio_i),
    .busy     (busy),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe),
    .done     (fe_done),
    .is_rd    (fe_is_rd),
    .phy_q    (fe_phy),
    .cap      (fe_cap)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag <= 1'b0;
      rd_data   <= '0;
      rd_phy    <= '0;
    end else begin
      if (fe_done)       done_flag <= 1'b1;
      else if (done_clr) done_flag <= 1'b0;
      if (fe_done && fe_is_rd) begin
        rd_data <= fe_cap;
        rd_phy  <= fe_phy;
      end
    end
  end
endmodule

// File: rtl/mdio_mgmt_chk.sv
`timescale 1ns/1ps
module mdio_mgmt_chk
  import mdio_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              ctl_we,
  input logic [CTL_W-1:0]  ctl_rdata,
  input logic              busy,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe,
  input logic              done_flag,
  input logic [DATA_W-1:0] rd_data,
  input logic [PHY_W-1:0]  rd_phy
);
  // R1
  wr_go_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[CTL_WR] && !ctl_we) |=> !ctl_rdata[CTL_WR]);
  // R1
  rd_go_selfclear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[CTL_RD] && !ctl_we) |=> !ctl_rdata[CTL_RD]);
  // R11
  mdc_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  // R11
  oe_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdio_oe);
  // R11
  mdo_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mdio_o) |-> !mdc);
  // R11
  mdc_high_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |=> mdc);
  // R12
  mdc_inside_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdc) |-> busy);
  // R10
  result_with_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(rd_data) || !$stable(rd_phy)) |-> done_flag);
endmodule

bind mdio_mgmt_master mdio_mgmt_chk u_chk (.*);

// File: tb/mdio_mgmt_master_bench.sv
`timescale 1ns/1ps
module mdio_mgmt_master_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctl_we = 1'b0;
  logic [4:0]  ctl_wdata = '0;
  logic [4:0]  ctl_rdata;
  logic [4:0]  base_phy = '0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] wr_data = '0;
  logic [7:0]  div_cfg = 8'd4;
  logic        done_clr = 1'b0;
  logic        mdio_i = 1'b1;
  logic        mdc, mdio_o, mdio_oe, busy, done_flag;
  logic [15:0] rd_data;
  logic [4:0]  rd_phy;

  always #2.5 clk = ~clk;

  mdio_mgmt_master u_mdio_mgmt_master (.*);

  int n_run = 0;
  int n_fail = 0;
  bit reported = 1'b0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] reply(input logic [4:0] p, input logic [4:0] r);
    return {3'b101, p, r, 3'b011};
  endfunction

  // PHY model: captures driven bits on MDC rise, answers reads after MDC fall
  logic        mdc_q = 1'b0, busy_q = 1'b0;
  int          pos_cnt = 0, cap_n = 0, oe_low_n = 0, frames = 0;
  int          busy_len = 0, rise_gap = 0, last_period = 0;
  logic [63:0] cap = '0;
  bit          b_pre = 1'b1;
  int          dstart;
  logic [15:0] rb;
  assign dstart = b_pre ? 48 : 16;
  assign rb = reply(cap[9:5], cap[4:0]);

  always @(posedge clk) begin
    mdc_q  <= mdc;
    busy_q <= busy;
    if (busy && !busy_q) begin
      frames <= frames + 1; pos_cnt <= 0; cap <= '0; cap_n <= 0; oe_low_n <= 0; busy_len <= 1;
    end else if (busy) begin
      busy_len <= busy_len + 1;
    end
    if (mdc && !mdc_q) begin
      pos_cnt <= pos_cnt + 1;
      last_period <= rise_gap;
      rise_gap <= 1;
      if (mdio_oe) begin cap <= {cap[62:0], mdio_o}; cap_n <= cap_n + 1; end
      else oe_low_n <= oe_low_n + 1;
    end else begin
      rise_gap <= rise_gap + 1;
    end
    if (!mdc && mdc_q) begin
      if (pos_cnt >= dstart && pos_cnt < dstart + 16) mdio_i <= rb[15 - (pos_cnt - dstart)];
      else mdio_i <= 1'b1;
    end
  end

  task automatic ctl_write(input logic [4:0] v);
    @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk); ctl_we = 1'b0;
  endtask

  task automatic wait_frame();
    while (!busy) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic clear_done();
    @(negedge clk); done_clr = 1'b1;
    @(negedge clk); done_clr = 1'b0;
  endtask

  task automatic finish_up();
    if (!reported) begin
      reported = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // {write, preamble_off, phy, reg, data}
  localparam logic [27:0] VEC [6] = '{
    {1'b1, 1'b0, 5'd1,  5'd0,  16'h1234},
    {1'b0, 1'b0, 5'd2,  5'd1,  16'h0000},
    {1'b1, 1'b1, 5'd31, 5'd31, 16'hA5C3},
    {1'b0, 1'b1, 5'd17, 5'd4,  16'h0000},
    {1'b1, 1'b1, 5'd0,  5'd16, 16'h0001},
    {1'b0, 1'b0, 5'd9,  5'd30, 16'h0000}
  };

  initial begin
    repeat (150000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 R11 R12: reset state
    check(ctl_rdata == 5'd0, "R1 reset ctl", 64'(ctl_rdata), 0);
    check(!busy, "R12 reset busy", 64'(busy), 0);
    check(!mdc && !mdio_oe, "R11 idle mdc/oe", {mdc, mdio_oe}, 0);
    check(!done_flag && rd_data == 16'd0, "R10 reset result", {done_flag, rd_data}, 0);

    // R1: readback of non-go fields
    ctl_write(5'b00100);
    check(ctl_rdata == 5'b00100, "R1 readback", 64'(ctl_rdata), 64'h4);
    ctl_write(5'b00000);

    // R1: go bit visible then self-cleared
    base_phy = 5'd3; reg_addr = 5'd2; b_pre = 1'b0;
    ctl_write(5'b01001);
    check(ctl_rdata == 5'b01001, "R1 go set", 64'(ctl_rdata), 64'h9);
    @(negedge clk);
    check(ctl_rdata == 5'b00001, "R1 go selfclear", 64'(ctl_rdata), 64'h1);
    wait_frame();
    clear_done();

    // vector table: single frames
    for (int i = 0; i < 6; i++) begin
      logic [27:0] v;
      logic [63:0] full;
      int f0;
      v = VEC[i];
      b_pre = !v[26];
      base_phy = v[25:21]; reg_addr = v[20:16]; wr_data = v[15:0];
      f0 = frames;
      ctl_write({v[27], !v[27], 2'b00, v[26]});
      wait_frame();
      repeat (2) @(negedge clk);
      check(frames == f0 + 1, "R2 R3 one frame", 64'(frames), 64'(f0 + 1));
      if (v[27]) begin
        full = {32'hFFFF_FFFF, 4'b0101, v[25:21], v[20:16], 2'b10, v[15:0]};
        if (v[26]) full = {32'h0, full[31:0]};
        check(cap == full, v[26] ? "R5 write frame" : "R2 write frame", cap, full);
        check(cap_n == (v[26] ? 32 : 64), "R5 bit count", 64'(cap_n), 64'(v[26] ? 32 : 64));
        check(busy_len == 4 * (v[26] ? 32 : 64), "R12 busy length", 64'(busy_len), 64'(4 * (v[26] ? 32 : 64)));
      end else begin
        check(cap[13:0] == {4'b0110, v[25:21], v[20:16]}, "R3 read header", 64'(cap[13:0]), 64'({4'b0110, v[25:21], v[20:16]}));
        check(cap_n == (v[26] ? 14 : 46), "R5 driven bits", 64'(cap_n), 64'(v[26] ? 14 : 46));
        check(oe_low_n == 18, "R3 released bits", 64'(oe_low_n), 64'd18);
        check(rd_data == reply(v[25:21], v[20:16]), "R3 read data", 64'(rd_data), 64'(reply(v[25:21], v[20:16])));
        check(rd_phy == v[25:21], "R3 read phy", 64'(rd_phy), 64'(v[25:21]));
      end
      check(done_flag, "R10 done set", 64'(done_flag), 1);
      clear_done();
      @(negedge clk);
      check(!done_flag, "R10 done clear", 64'(done_flag), 0);
    end

    // R4: read command while busy is ignored
    begin
      int f0;
      b_pre = 1'b1; base_phy = 5'd4; reg_addr = 5'd1; wr_data = 16'hBEEF;
      f0 = frames;
      ctl_write(5'b10000);
      while (!busy) @(negedge clk);
      ctl_write(5'b01000);
      while (busy) @(negedge clk);
      repeat (400) @(negedge clk);
      check(frames == f0 + 1 && !busy, "R4 ignored while busy", 64'(frames), 64'(f0 + 1));
    end

    // R6 R7: stepping scan wraps from 1Fh to base
    base_phy = 5'd30; reg_addr = 5'd7; b_pre = 1'b0;
    ctl_write(5'b00111);
    for (int k = 0; k < 4; k++) begin
      logic [4:0] ep;
      ep = (k % 2 == 0) ? 5'd30 : 5'd31;
      wait_frame();
      @(negedge clk);
      check(rd_phy == ep, "R7 scan address", 64'(rd_phy), 64'(ep));
      check(rd_data == reply(ep, 5'd7), "R6 scan data", 64'(rd_data), 64'(reply(ep, 5'd7)));
    end

    // R9: stop scan mid-frame
    begin
      int fn;
      while (!busy) @(negedge clk);
      ctl_write(5'b00000);
      while (busy) @(negedge clk);
      repeat (2) @(negedge clk);
      fn = frames;
      check(pos_cnt == 32, "R9 frame completed", 64'(pos_cnt), 64'd32);
      repeat (300) @(negedge clk);
      check(frames == fn && !busy, "R9 no frame after stop", 64'(frames), 64'(fn));
    end

    // R8: scan without stepping
    base_phy = 5'd5; reg_addr = 5'd9;
    ctl_write(5'b00011);
    for (int k = 0; k < 3; k++) begin
      wait_frame();
      @(negedge clk);
      check(rd_phy == 5'd5, "R8 fixed scan address", 64'(rd_phy), 64'd5);
    end
    ctl_write(5'b00000);
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);

    // R11: MDC period from divide setting
    for (int d = 0; d < 3; d++) begin
      int dv, ep;
      dv = (d == 0) ? 10 : ((d == 1) ? 3 : 7);
      ep = (d == 0) ? 10 : ((d == 1) ? 4 : 6);
      div_cfg = 8'(dv);
      ctl_write(5'b10001);
      wait_frame();
      check(last_period == ep, "R11 mdc period", 64'(last_period), 64'(ep));
    end
    div_cfg = 8'd4;
    @(negedge clk);
    check(!mdc && !mdio_oe, "R11 idle after frames", {mdc, mdio_oe}, 0);

    finish_up();
  end
endmodule